// File: doc/BRIEF.md
# Header Gap Realigner with HEC Slot Insertion

This block sits in a cell transmit path. Its input is a continuous stream of 32-bit words that carry 52-byte cells. Each cell is a 4-byte header followed by 48 payload bytes, and the check byte is missing. For every cell the block opens a one-byte slot directly after the header and writes a check byte into that slot. The check byte is computed elsewhere and arrives on an input. The output is a gapless stream of 53-byte cells packed into 32-bit words.

Four 53-byte cells fill exactly 53 output words, but they come from only 52 input words. For this reason the block pauses its upstream for one cycle in every 53. Byte placement follows a six-state one-hot ring that repeats with the same 53-cycle period:

- four steady states apply a byte lag of 0, 1, 2 or 3 lanes;
- two single-cycle states switch the lag at the moment the slot opens in the middle of a word.

A two-bit counter tracks which lane receives the check byte, and it moves to the next lane at each insertion.

The stream must be cell-aligned from reset: the first word offered after reset release is the header word of a cell. Lane 0 of every word is bits [31:24] and is the first byte in stream order.

Top module: `hdr_gap_realigner`

## Requirements
- R1: While `rst` is high, and at the first sampling after it is released, `out_valid` is 0 and `in_hold` is 0. A reset in mid-stream restarts the alignment, so the next word offered is again taken as a cell header.
- R2: `out_valid` first reads 1 after the second rising clock edge following reset release. The word it flags holds the four header bytes of the first cell, lane 0 (bits [31:24]) first.
- R3: Once `out_valid` is 1 it stays 1 on every following cycle until the next reset, so output words are produced back to back.
- R4: `in_hold` is high for exactly one cycle in every 53. Counting the cycle right after reset release as cycle 0, it is first high in cycle 41. No input word is taken in a cycle where `in_hold` is high.
- R5: Reading the output bytes in stream order (word by word, lane 0 first) gives, for each cell: its 4 header bytes, then its check byte, then its 48 payload bytes. Cells follow one another with no gap or filler.
- R6: The check byte for a cell is the value on `in_hec` in the cycle that cell's header word is accepted. `in_hec` is ignored in every other cycle.
- R7: The check byte falls in lane 0, 1, 2 and 3 for four consecutive cells, and this cycle repeats. These are output words 1, 14, 27 and 40 of each 53-word period.
- R8: Every 53-word output period starts with a header word aligned to lane 0. This holds because the new-word and previous-word registers keep their contents during the hold cycle.
- R9: The values on `in_word` and `in_hec` during a cycle with `in_hold` high have no effect on any output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 32 | Input word of a 52-byte cell, lane 0 in bits [31:24] |
| in_hec | input | 8 | Check byte, sampled together with the header word |
| in_hold | output | 1 | Upstream stall: the current input word is not taken |
| out_word | output | 32 | Realigned output word, lane 0 in bits [31:24] |
| out_valid | output | 1 | Output word is meaningful |

## Verification
The bench targets these corner cases:

- **Slot words.** Words 1, 14, 27 and 40 of each period hold the check byte. A wrong lane counter or wrong transition state here would put the check byte in the wrong lane, or overwrite a header byte.
- **The word after the stall.** If the stall let the previous or new register advance, this word would repeat or skip four bytes.
- **Junk while stalled.** Random data is driven on both inputs during the hold cycle. A design that loaded it would corrupt the next period's header.
- **Reset in mid-stream.** This catches a phase counter that fails to restart.
- **Extreme byte values.** Cells of all-zero and all-one bytes, each paired with the opposite check byte, show whether a missing or shifted byte would go unnoticed.

// File: rtl/rlgn_pkg.sv
package rlgn_pkg;

    localparam int LANES         = 4;
    localparam int BYTE_W        = 8;
    localparam int WORD_W        = LANES * BYTE_W;
    localparam int HDR_BYTES     = 4;
    localparam int CELL_IN_BYTES = 52;
    localparam int CELL_IN_WORDS = CELL_IN_BYTES / LANES;
    localparam int SUPER_CELLS   = LANES;
    localparam int PERIOD        = SUPER_CELLS * (CELL_IN_BYTES + 1) / LANES;
    localparam int PH_W          = $clog2(PERIOD);
    localparam int LANE_W        = $clog2(LANES);

    typedef logic [BYTE_W-1:0]            byte_t;
    typedef logic [LANES-1:0][BYTE_W-1:0] word_t;
    typedef logic [PH_W-1:0]              phase_t;
    typedef logic [LANE_W-1:0]            lane_t;

    // one-hot ring of byte-lag states
    typedef enum logic [5:0] {
        SH_LAG0  = 6'b000001,
        SH_LAG1  = 6'b000010,
        SH_TR12  = 6'b000100,
        SH_LAG2  = 6'b001000,
        SH_TR23  = 6'b010000,
        SH_LAG3  = 6'b100000
    } shift_e;

    typedef struct packed {
        logic   hold;
        logic   insert;
        logic   hdr_load;
        shift_e shift;
    } ctrl_t;

    // output word index within a period that carries the check byte of cell c
    function automatic int hole_phase(input int c);
        return (c * (CELL_IN_BYTES + 1) + HDR_BYTES) / LANES;
    endfunction

    function automatic int jerk_phase();
        return hole_phase(SUPER_CELLS - 1);
    endfunction

    // phase in which the header word of cell c is loaded into the new register
    function automatic int hdr_load_phase(input int c);
        int n;
        n = c * CELL_IN_WORDS;
        if (c == 0)                return PERIOD - 1;
        else if (n <= jerk_phase()) return n - 1;
        else                       return n;
    endfunction

    // last phase spent in a given ring state
    function automatic int end_phase(input shift_e s);
        case (s)
            SH_LAG0: return hole_phase(0) - 1;
            SH_LAG1: return hole_phase(1) - 1;
            SH_TR12: return hole_phase(1);
            SH_LAG2: return hole_phase(2) - 1;
            SH_TR23: return hole_phase(2);
            SH_LAG3: return hole_phase(3);
            default: return 0;
        endcase
    endfunction

    // byte lag applied to a lane; during a transition the slot sits at lane d
    function automatic int lag_of(input shift_e s, input int lane);
        case (s)
            SH_LAG0: return 0;
            SH_LAG1: return 1;
            SH_TR12: return (lane < 1) ? 1 : 2;
            SH_LAG2: return 2;
            SH_TR23: return (lane < 2) ? 2 : 3;
            SH_LAG3: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic byte_t lane_get(input word_t w, input int lane);
        return w[LANES-1-lane];
    endfunction

    // byte idx of the concatenation {prev, new} in stream order
    function automatic byte_t pick_byte(input word_t prev_w, input word_t new_w, input int idx);
        if (idx < 0)          return lane_get(prev_w, 0);
        else if (idx < LANES) return lane_get(prev_w, idx);
        else if (idx < 2*LANES) return lane_get(new_w, idx - LANES);
        else                  return lane_get(new_w, LANES - 1);
    endfunction

endpackage

// File: rtl/rlgn_sequencer.sv
module rlgn_sequencer
    import rlgn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output ctrl_t ctrl
);
    phase_t ph_q;
    shift_e state_q;

    logic at_end;
    logic is_hole;
    logic is_hdr;

    always_comb begin
        at_end  = (ph_q == PH_W'(end_phase(state_q)));
        is_hole = 1'b0;
        is_hdr  = 1'b0;
        for (int c = 0; c < SUPER_CELLS; c++) begin
            if (ph_q == PH_W'(hole_phase(c)))     is_hole = 1'b1;
            if (ph_q == PH_W'(hdr_load_phase(c))) is_hdr  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_W'(PERIOD - 1);
            state_q <= SH_LAG0;
        end else begin
            ph_q <= (ph_q == PH_W'(PERIOD - 1)) ? '0 : ph_q + 1'b1;
            if (at_end)
                state_q <= shift_e'({state_q[4:0], state_q[5]});
        end
    end

    always_comb begin
        ctrl.hold     = (ph_q == PH_W'(jerk_phase()));
        ctrl.insert   = is_hole;
        ctrl.hdr_load = is_hdr;
        ctrl.shift    = state_q;
    end

    // R7
    ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);

    // R4
    hold_single_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.hold |=> !ctrl.hold);

    // R4
    hold_in_lag3_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.hold |-> (state_q == SH_LAG3));

endmodule

// File: rtl/rlgn_word_pair.sv
module rlgn_word_pair
    import rlgn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t in_word,
    output word_t new_w,
    output word_t prev_w
);
    word_t new_q;
    word_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            new_q  <= '0;
            prev_q <= '0;
        end else if (load) begin
            new_q  <= in_word;
            prev_q <= new_q;
        end
    end

    assign new_w  = new_q;
    assign prev_w = prev_q;

    // R8
    pair_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(prev_q) && $stable(new_q)));

endmodule

// File: rtl/rlgn_hec_slot.sv
module rlgn_hec_slot
    import rlgn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  logic   insert,
    input  shift_e shift,
    input  byte_t  hec_in,
    output byte_t  hec_byte,
    output lane_t  hec_lane
);
    byte_t hec_q;
    lane_t lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hec_q  <= '0;
            lane_q <= '0;
        end else begin
            if (capture) hec_q  <= hec_in;
            if (insert)  lane_q <= lane_q + 1'b1;
        end
    end

    assign hec_byte = hec_q;
    assign hec_lane = lane_q;

    // R7
    lane_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !insert |=> $stable(lane_q));

    // R7
    lane_tr12_chk: assert property (@(posedge clk) disable iff (rst)
        (insert && shift == SH_TR12) |-> (lane_q == LANE_W'(1)));

    // R7
    lane_tr23_chk: assert property (@(posedge clk) disable iff (rst)
        (insert && shift == SH_TR23) |-> (lane_q == LANE_W'(2)));

endmodule

// File: rtl/rlgn_lane_pack.sv
module rlgn_lane_pack
    import rlgn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  shift_e shift,
    input  logic   insert,
    input  logic   start,
    input  lane_t  hec_lane,
    input  byte_t  hec_byte,
    input  word_t  new_w,
    input  word_t  prev_w,
    output word_t  out_word,
    output logic   out_valid
);
    word_t packed_w;
    word_t out_q;
    logic  valid_q;

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic hole;
        int   src;
        always_comb begin
            hole = insert && (hec_lane == LANE_W'(L));
            src  = LANES + L - lag_of(shift, L);
            packed_w[LANES-1-L] = hole ? hec_byte : pick_byte(prev_w, new_w, src);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            out_q <= packed_w;
            if (start) valid_q <= 1'b1;
        end
    end

    assign out_word  = out_q;
    assign out_valid = valid_q;

    // R3
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q);

endmodule

// File: rtl/hdr_gap_realigner.sv
module hdr_gap_realigner
    import rlgn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_word,
    input  logic [BYTE_W-1:0] in_hec,
    output logic              in_hold,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid
);
    ctrl_t ctrl;
    word_t new_w;
    word_t prev_w;
    byte_t hec_byte;
    lane_t hec_lane;
    word_t pack_out;
    logic  period_start;

    rlgn_sequencer u_seq (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl)
    );

    rlgn_word_pair u_pair (
        .clk     (clk),
        .rst     (rst),
        .load    (!ctrl.hold),
        .in_word (word_t'(in_word)),
        .new_w   (new_w),
        .prev_w  (prev_w)
    );

    rlgn_hec_slot u_hec (
        .clk      (clk),
        .rst      (rst),
        .capture  (ctrl.hdr_load),
        .insert   (ctrl.insert),
        .shift    (ctrl.shift),
        .hec_in   (in_hec),
        .hec_byte (hec_byte),
        .hec_lane (hec_lane)
    );

    // first formatted word is produced in the cycle after the first header load
    logic primed_q;
    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end
    assign period_start = primed_q;

    rlgn_lane_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .shift     (ctrl.shift),
        .insert    (ctrl.insert),
        .start     (period_start),
        .hec_lane  (hec_lane),
        .hec_byte  (hec_byte),
        .new_w     (new_w),
        .prev_w    (prev_w),
        .out_word  (pack_out),
        .out_valid (out_valid)
    );

    assign out_word = pack_out;
    assign in_hold  = ctrl.hold;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !in_hold));

endmodule

// File: tb/tb_hdr_gap_realigner.sv
module tb_hdr_gap_realigner;
    localparam int CLK_PERIOD = 10;
    localparam int NCELL      = 24;
    localparam int CB         = 52;
    localparam int OCB        = 53;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_word = '0;
    logic [7:0]  in_hec = '0;
    logic        in_hold;
    logic [31:0] out_word;
    logic        out_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_gap_realigner dut (
        .clk       (clk),
        .rst       (rst),
        .in_word   (in_word),
        .in_hec    (in_hec),
        .in_hold   (in_hold),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

    logic [7:0] cb [NCELL*CB];
    logic [7:0] hb [NCELL];
    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int ncur  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int n);
        int c, p;
        c = n / OCB;
        p = n % OCB;
        if (p < 4)       return cb[c*CB + p];
        else if (p == 4) return hb[c];
        else             return cb[c*CB + p - 1];
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        return {exp_byte(4*w), exp_byte(4*w+1), exp_byte(4*w+2), exp_byte(4*w+3)};
    endfunction

    function automatic logic [31:0] src_word(input int k);
        if (k >= ncur * 13) return 32'h0;
        return {cb[4*k], cb[4*k+1], cb[4*k+2], cb[4*k+3]};
    endfunction

    function automatic string tag_of(input int w);
        case (w % OCB)
            0:          return "R8";
            1:          return "R6";
            14, 27, 40: return "R7";
            41:         return "R9";
            default:    return "R5";
        endcase
    endfunction

    task automatic gen(input int ncell, input bit directed);
        for (int i = 0; i < ncell*CB; i++) cb[i] = 8'($urandom);
        for (int c = 0; c < ncell; c++)    hb[c] = 8'($urandom);
        if (directed) begin
            for (int i = 0; i < CB; i++) begin
                cb[i]      = 8'h00;
                cb[CB+i]   = 8'hFF;
                cb[2*CB+i] = 8'(i);
            end
            hb[0] = 8'hFF;
            hb[1] = 8'h00;
            hb[2] = 8'hA5;
        end
        ncur = ncell;
    endtask

    task automatic run(input int ncell);
        int  k;
        int  nwords;
        bit  accept;
        logic exp_hold;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        k = 0;
        nwords = ncell * OCB / 4;
        for (int n = 0; n <= nwords + 1; n++) begin
            if (n == 0) begin
                chk(out_valid == 1'b0, "R1", 32'(out_valid), 32'h0);
                chk(in_hold == 1'b0, "R1", 32'(in_hold), 32'h0);
            end else begin
                chk(out_valid == (n >= 2), (n == 2) ? "R2" : "R3", 32'(out_valid), 32'(n >= 2));
            end
            if (n >= 2)
                chk(out_word == exp_word(n-2), (n == 2) ? "R2" : tag_of(n-2), out_word, exp_word(n-2));
            exp_hold = (n % OCB == 41);
            chk(in_hold == exp_hold, "R4", 32'(in_hold), 32'(exp_hold));
            if (in_hold) begin
                // R9: junk while stalled
                in_word = $urandom;
                in_hec  = 8'($urandom);
            end else begin
                in_word = src_word(k);
                in_hec  = (k % 13 == 0 && k / 13 < ncell) ? hb[k/13] : 8'($urandom);
            end
            accept = !in_hold;
            @(negedge clk);
            if (accept) k++;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        gen(NCELL, 1'b1);
        run(NCELL);
        // R1: reset in mid-stream, new data
        gen(8, 1'b0);
        run(8);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule